// File: doc/BRIEF.md
# Single-Flag Carry, Overflow and Rotate ALU

This block is a 32-bit arithmetic and rotate datapath built around one status bit, called the flag. The flag serves as carry-in and carry-out for add and subtract with carry. It serves as the borrow for negate and as the overflow indicator for the signed add and subtract. For the two rotates, the flag is the bit shifted in and the bit shifted out. Each opcode has its own rule for how the next flag value is formed.

The result is combinational. It depends on the operands, the opcode and the current flag. The flag is a register that loads the operation's new value on a rising clock edge when the strobe is high. Data enters as a strobed operand pair. The block completes any operation in one cycle and never applies back-pressure, so there is no ready signal: every strobed cycle is taken. A caller that needs a chain of carries keeps the strobe high on consecutive cycles, and each step uses the flag that the step before it left behind.

Top module: `tbit_alu`

## Requirements
- R1: A synchronous active-high reset clears the flag to 0 at the next rising edge.
- R2: Opcode 0 (add with carry) gives result = dst + src + flag mod 2^32. The next flag is 1 exactly when the true sum is 2^32 or more.
- R3: Opcode 2 (subtract with carry) gives result = dst - src - flag mod 2^32. The next flag is 1 exactly when src + flag is greater than dst as unsigned values.
- R4: Opcode 4 (negate with carry) gives result = 0 - src - flag mod 2^32. The next flag is 1 when src is nonzero or the old flag is 1.
- R5: Opcode 1 (add with overflow) gives result = dst + src mod 2^32. The next flag is 1 only when both operands share a sign (bit 31) and the result's bit 31 differs from it.
- R6: Opcode 3 (subtract with overflow) gives result = dst - src mod 2^32. The next flag is 1 only when the operands' bit 31 differ and the result's bit 31 differs from dst's.
- R7: Opcode 5 (rotate left) gives result = {src[30:0], flag}. The next flag is src[31].
- R8: Opcode 6 (rotate right) gives result = {flag, src[31:1]}. The next flag is src[0].
- R9: The flag changes only on an edge where op_valid is 1. With op_valid at 0 the result is still driven, but the flag holds.
- R10: Opcode 7 is reserved. It raises illegal_op, makes result equal dst, and leaves the flag unchanged even when strobed.
- R11: The result reflects the present inputs and flag in the same cycle, with no register on its path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Strobe; the flag loads only when high |
| op_code | input | 3 | Operation select (encoding in R2-R10 items) |
| src_opnd | input | 32 | Source operand |
| dst_opnd | input | 32 | Destination operand |
| result | output | 32 | Combinational result |
| t_flag | output | 1 | Registered flag |
| illegal_op | output | 1 | High while op_code is the reserved value |

## Verification
The assertions assume that op_code, op_valid and the operands are settled before each rising edge and carry no X. They also assume that reset is applied before the first strobe. The bench drives every input on the falling edge and releases reset before it issues any operation, so both conditions hold throughout. Opcodes and operands are drawn at random from all 3-bit and 32-bit values, so the reserved opcode and unstrobed cycles appear alongside the directed carry, borrow and overflow corners.

// File: rtl/tbit_alu_pkg.sv
package tbit_alu_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned OP_W   = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADDC = 3'd0,
    OP_ADDV = 3'd1,
    OP_SUBC = 3'd2,
    OP_SUBV = 3'd3,
    OP_NEGC = 3'd4,
    OP_ROTL = 3'd5,
    OP_ROTR = 3'd6,
    OP_RSVD = 3'd7
  } alu_op_e;
endpackage

// File: rtl/tbit_arith.sv
module tbit_arith #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         flag_in,
  input  logic         zero_dst,
  output logic [W-1:0] addc_res,
  output logic         addc_flag,
  output logic [W-1:0] subc_res,
  output logic         subc_flag,
  output logic [W-1:0] addv_res,
  output logic         addv_flag,
  output logic [W-1:0] subv_res,
  output logic         subv_flag
);
  localparam int unsigned MSB = W - 1;

  logic [W-1:0] b_eff;
  logic [W:0]   add1, add2, sub1, sub2;

  always_comb begin
    b_eff = zero_dst ? '0 : b_in;
    add1  = {1'b0, b_in} + {1'b0, a_in};
    add2  = {1'b0, add1[W-1:0]} + {{W{1'b0}}, flag_in};
    sub1  = {1'b0, b_eff} - {1'b0, a_in};
    sub2  = {1'b0, sub1[W-1:0]} - {{W{1'b0}}, flag_in};

    addc_res  = add2[W-1:0];
    addc_flag = add1[W] | add2[W];
    subc_res  = sub2[W-1:0];
    subc_flag = sub1[W] | sub2[W];

    addv_res  = add1[W-1:0];
    addv_flag = (a_in[MSB] == b_in[MSB]) && (add1[MSB] != b_in[MSB]);
    subv_res  = sub1[W-1:0];
    subv_flag = (a_in[MSB] != b_in[MSB]) && (sub1[MSB] != b_in[MSB]);
  end
endmodule

// File: rtl/tbit_rotate.sv
module tbit_rotate #(
  parameter int unsigned W    = 32,
  parameter bit          LEFT = 1'b1
) (
  input  logic [W-1:0] val_in,
  input  logic         flag_in,
  output logic [W-1:0] val_out,
  output logic         flag_out
);
  generate
    if (LEFT) begin : g_left
      assign val_out  = {val_in[W-2:0], flag_in};
      assign flag_out = val_in[W-1];
    end else begin : g_right
      assign val_out  = {flag_in, val_in[W-1:1]};
      assign flag_out = val_in[0];
    end
  endgenerate
endmodule

// File: rtl/tbit_flag_reg.sv
module tbit_flag_reg (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic next_val,
  output logic flag_q
);
  always_ff @(posedge clk) begin
    if (rst)       flag_q <= 1'b0;
    else if (load) flag_q <= next_val;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> !flag_q); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !load |=> flag_q == $past(flag_q)); // R9
endmodule

// File: rtl/tbit_alu.sv
module tbit_alu
  import tbit_alu_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            op_valid,
  input  logic [OP_W-1:0] op_code,
  input  logic [W-1:0]    src_opnd,
  input  logic [W-1:0]    dst_opnd,
  output logic [W-1:0]    result,
  output logic            t_flag,
  output logic            illegal_op
);
  localparam int unsigned MSB = W - 1;

  alu_op_e      op;
  logic [W-1:0] addc_r, subc_r, addv_r, subv_r, rotl_r, rotr_r;
  logic         addc_t, subc_t, addv_t, subv_t, rotl_t, rotr_t;
  logic         t_next, t_load;

  assign op = alu_op_e'(op_code);

  tbit_arith #(.W(W)) u_arith (
    .a_in(src_opnd), .b_in(dst_opnd), .flag_in(t_flag),
    .zero_dst(op == OP_NEGC),
    .addc_res(addc_r), .addc_flag(addc_t),
    .subc_res(subc_r), .subc_flag(subc_t),
    .addv_res(addv_r), .addv_flag(addv_t),
    .subv_res(subv_r), .subv_flag(subv_t)
  );

  tbit_rotate #(.W(W), .LEFT(1'b1)) u_rotl (
    .val_in(src_opnd), .flag_in(t_flag), .val_out(rotl_r), .flag_out(rotl_t)
  );

  tbit_rotate #(.W(W), .LEFT(1'b0)) u_rotr (
    .val_in(src_opnd), .flag_in(t_flag), .val_out(rotr_r), .flag_out(rotr_t)
  );

  always_comb begin
    illegal_op = 1'b0;
    result     = dst_opnd;
    t_next     = t_flag;
    unique case (op)
      OP_ADDC: begin result = addc_r; t_next = addc_t; end
      OP_ADDV: begin result = addv_r; t_next = addv_t; end
      OP_SUBC,
      OP_NEGC: begin result = subc_r; t_next = subc_t; end
      OP_SUBV: begin result = subv_r; t_next = subv_t; end
      OP_ROTL: begin result = rotl_r; t_next = rotl_t; end
      OP_ROTR: begin result = rotr_r; t_next = rotr_t; end
      default: illegal_op = 1'b1;
    endcase
  end

  assign t_load = op_valid && !illegal_op;

  tbit_flag_reg u_flag (
    .clk(clk), .rst(rst), .load(t_load), .next_val(t_next), .flag_q(t_flag)
  );

  AST_RSVD_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_RSVD) |=> t_flag == $past(t_flag)); // R10
  AST_ROTL_OUT: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_ROTL) |=> t_flag == $past(src_opnd[MSB])); // R7
  AST_ROTR_OUT: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_ROTR) |=> t_flag == $past(src_opnd[0])); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_ADDV && src_opnd[MSB] != dst_opnd[MSB])
      |=> !t_flag); // R5
endmodule

// File: tb/tbit_alu_tb_top.sv
module tbit_alu_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = 3'd0;
  logic [31:0] src_opnd = '0;
  logic [31:0] dst_opnd = '0;
  logic [31:0] result;
  logic        t_flag;
  logic        illegal_op;

  int errors = 0;
  int checks = 0;
  logic exp_t = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tbit_alu dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .src_opnd(src_opnd), .dst_opnd(dst_opnd),
    .result(result), .t_flag(t_flag), .illegal_op(illegal_op)
  );

  function automatic logic [32:0] model(input logic [2:0] op,
      input logic [31:0] a, input logic [31:0] b, input logic t);
    logic [63:0] u;
    longint      s;
    logic [31:0] r;
    logic        tn;
    r = b; tn = t;
    case (op)
      3'd0: begin u = 64'(b) + 64'(a) + 64'(t); r = u[31:0]; tn = (u >= 64'h1_0000_0000); end
      3'd1: begin s = longint'($signed(b)) + longint'($signed(a)); r = b + a;
                  tn = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
      3'd2: begin r = b - a - 32'(t); tn = (64'(a) + 64'(t)) > 64'(b); end
      3'd3: begin s = longint'($signed(b)) - longint'($signed(a)); r = b - a;
                  tn = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
      3'd4: begin r = 32'd0 - a - 32'(t); tn = (a != 0) || t; end
      3'd5: begin r = {a[30:0], t}; tn = a[31]; end
      3'd6: begin r = {t, a[31:1]}; tn = a[0]; end
      default: begin r = b; tn = t; end
    endcase
    return {tn, r};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [2:0] op);
    case (op)
      3'd0: return "R2"; 3'd1: return "R5"; 3'd2: return "R3"; 3'd3: return "R6";
      3'd4: return "R4"; 3'd5: return "R7"; 3'd6: return "R8"; default: return "R10";
    endcase
  endfunction

  task automatic do_op(input logic [2:0] op, input logic [31:0] a,
      input logic [31:0] b, input logic v);
    logic [32:0] m;
    @(negedge clk);
    op_code = op; src_opnd = a; dst_opnd = b; op_valid = v;
    #1;
    m = model(op, a, b, exp_t);
    chk({req_of(op), "/R11 result"}, result, m[31:0]);
    chk("R10 illegal_op", 32'(illegal_op), 32'(op == 3'd7));
    @(posedge clk); #1;
    if (v) exp_t = m[32];
    chk(v ? {req_of(op), " flag"} : "R9 flag", 32'(t_flag), 32'(exp_t));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'd1234);
    repeat (2) @(posedge clk);
    #1;
    chk("R1 reset flag", 32'(t_flag), 32'd0);
    @(negedge clk); rst = 1'b0;
    // directed corners
    do_op(3'd0, 32'h0000_0000, 32'hFFFF_FFFF, 1'b1); // R2 no carry
    do_op(3'd5, 32'h8000_0000, 32'h0, 1'b1);          // R7 flag -> 1
    do_op(3'd0, 32'h0000_0000, 32'hFFFF_FFFF, 1'b1); // R2 carry from flag add
    do_op(3'd2, 32'h0, 32'h0, 1'b1);                  // R3 borrow from flag
    do_op(3'd4, 32'h0, 32'h0, 1'b1);                  // R4 zero src, flag 1
    do_op(3'd6, 32'h0000_0002, 32'h0, 1'b1);          // R8 flag -> 0
    do_op(3'd4, 32'h0, 32'h0, 1'b1);                  // R4 zero src, flag 0
    do_op(3'd1, 32'h0000_0001, 32'h7FFF_FFFF, 1'b1);  // R5 overflow
    do_op(3'd3, 32'h0000_0001, 32'h8000_0000, 1'b1);  // R6 overflow
    do_op(3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);  // R9 no strobe
    do_op(3'd7, 32'h1234_5678, 32'hCAFE_F00D, 1'b1);  // R10 reserved
    do_op(3'd6, 32'h0000_0001, 32'h0, 1'b1);          // R8 flag -> 1
    do_op(3'd7, 32'h0, 32'h0BAD_BEEF, 1'b1);          // R10 holds 1
    // rotate chain using flag as carry
    for (int i = 0; i < 4; i++) do_op(3'd5, 32'hA5A5_0F0F << i, 32'h0, 1'b1);
    // random mix
    for (int i = 0; i < 3000; i++)
      do_op(3'($urandom), $urandom, $urandom, ($urandom % 4) != 0);
    // reset mid-run
    @(negedge clk); rst = 1'b1; op_valid = 1'b0;
    @(posedge clk); #1;
    exp_t = 1'b0;
    chk("R1 reset flag", 32'(t_flag), 32'd0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule